// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Request Unit

This block turns one external pin into a maskable interrupt request for a small 8-bit processor. The pin passes through a two-stage synchronizer. Each new sample is compared with the one before it to find rising and falling transitions. A two-bit edge-select code in an 8-bit mode register decides which transitions count as valid. A valid transition latches a request flag. That flag is gated by a mask bit and by a global interrupt-enable bit kept in an 8-bit status word.

Software reaches the mode register, the flag, the mask and the status word through a small byte-wide register port with a 2-bit address. Two one-cycle command inputs set and clear the global enable directly. When the processor takes the interrupt, it pulses the acknowledge input. During that cycle the block drives the current status word on a dedicated output so it can be saved. On the same clock edge it clears the global enable and the request flag.

The usual software sequence is as follows. Set the mask, write the mode register, clear the flag, then clear the mask.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset, reads return 00H from the mode register (address 0), 0 from the flag (address 1), 1 from the mask (address 2) and 02H from the status word (address 3). The request output is low.
- R2: A write to address 0 stores only bits 1:0. Bits 7:2 of the mode register always read back as 0.
- R3: Code 00 selects falling edges. A 1-to-0 change on the pin that is held for three clock edges sets the flag on the third rising clock edge after the pin changes.
- R4: Code 01 selects rising edges, with the same three-edge latency as R3.
- R5: Code 11 makes both rising and falling edges set the flag.
- R6: Code 10 selects no edge, so pin activity never sets the flag.
- R7: The request output is high exactly when the flag is 1, the mask is 0 and status bit 7 (global enable) is 1.
- R8: While the acknowledge input is high, the save output carries the current status word. At all other times it is 00H. At the end of an acknowledge cycle the enable bit is 0 and the flag is 0.
- R9: A pulse on the enable command sets status bit 7 and a pulse on the disable command clears it. Acknowledge has the highest priority, then disable, then enable, then a bus write to bit 7.
- R10: A write to address 3 stores bits 7, 6, 4 and 0. Bit 1 always reads 1 and bits 5, 3 and 2 always read 0.
- R11: A valid edge in the same cycle as a software clear of the flag, or as an acknowledge, leaves the flag set.
- R12: Writes to addresses 1 and 2 load the flag and the mask from bit 0. Bits 7:1 of those addresses always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| pin_i | input | 1 | External interrupt pin, asynchronous |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 mode, 1 flag, 2 mask, 3 status word |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| en_cmd_i | input | 1 | Set global enable |
| dis_cmd_i | input | 1 | Clear global enable |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| irq_o | output | 1 | Interrupt request to the processor |
| save_o | output | 8 | Status word presented during acknowledge |

## Verification
Two events can collide in the same cycle: a detected edge on the pin, and a clear of the request flag from either a bus write or an acknowledge. The bench moves a software clear across every offset around a pin transition, and also acknowledges while edges are arriving. A behavioural model applies the priority rule of R11 and is compared every clock. A second collision is the global-enable bit, which can receive an acknowledge, both commands and a bus write at once. Directed and pseudo-random stimulus combine these, and the resulting status word is checked against the order fixed in R9.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    SEL_FALL = 2'b00,
    SEL_RISE = 2'b01,
    SEL_NONE = 2'b10,
    SEL_BOTH = 2'b11
  } edge_sel_e;

  localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] A_FLAG = 2'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

  localparam int                STAT_IE_BIT = 7;
  localparam logic [DATA_W-1:0] STAT_WR_MSK = 8'hD1;
  localparam logic [DATA_W-1:0] STAT_ONES   = 8'h02;
  localparam logic [DATA_W-1:0] STAT_RST    = 8'h02;
endpackage

// File: rtl/eirq_edge_det.sv
module eirq_edge_det
  import eirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_i,
  input  edge_sel_e sel_i,
  output logic      hit_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q;
  logic                   cur, rise, fall;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
    end else begin : g_single
      always_comb sync_d = pin_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= cur;
    end
  end

  always_comb begin
    cur  = sync_q[SYNC_STAGES-1];
    rise = cur & ~prev_q;
    fall = ~cur & prev_q;
    unique case (sel_i)
      SEL_FALL: hit_o = fall;
      SEL_RISE: hit_o = rise;
      SEL_BOTH: hit_o = rise | fall;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/eirq_req.sv
module eirq_req (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic ack_i,
  input  logic flag_we_i,
  input  logic mask_we_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic mask_o
);
  logic flag_q, flag_d, mask_q, mask_d;

  always_comb begin
    flag_d = flag_q;
    if (hit_i)          flag_d = 1'b1;
    else if (ack_i)     flag_d = 1'b0;
    else if (flag_we_i) flag_d = wbit_i;
    mask_d = mask_we_i ? wbit_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      mask_q <= 1'b1;
    end else begin
      flag_q <= flag_d;
      mask_q <= mask_d;
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/eirq_status.sv
module eirq_status
  import eirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  input  logic              en_i,
  input  logic              dis_i,
  output logic [DATA_W-1:0] stat_o
);
  logic [DATA_W-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (we_i) stat_d = (wdata_i & STAT_WR_MSK) | STAT_ONES;
    if (ack_i || dis_i) stat_d[STAT_IE_BIT] = 1'b0;
    else if (en_i)      stat_d[STAT_IE_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= STAT_RST;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import eirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              en_cmd_i,
  input  logic              dis_cmd_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] save_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  edge_sel_e         mode_q, mode_d;
  logic              hit, flag, mask;
  logic [DATA_W-1:0] stat;
  logic              we_mode, we_flag, we_mask, we_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    we_mode = bus_wr_i && (bus_addr_i == A_MODE);
    we_flag = bus_wr_i && (bus_addr_i == A_FLAG);
    we_mask = bus_wr_i && (bus_addr_i == A_MASK);
    we_stat = bus_wr_i && (bus_addr_i == A_STAT);
    mode_d  = we_mode ? edge_sel_e'(bus_wdata_i[1:0]) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) mode_q <= SEL_FALL;
    else            mode_q <= mode_d;
  end

  eirq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_int_n), .pin_i(pin_i), .sel_i(mode_q), .hit_o(hit)
  );

  eirq_req u_req (
    .clk(clk), .rst_n(rst_int_n), .hit_i(hit), .ack_i(ack_i),
    .flag_we_i(we_flag), .mask_we_i(we_mask), .wbit_i(bus_wdata_i[0]),
    .flag_o(flag), .mask_o(mask)
  );

  eirq_status u_stat (
    .clk(clk), .rst_n(rst_int_n), .we_i(we_stat), .wdata_i(bus_wdata_i),
    .ack_i(ack_i), .en_i(en_cmd_i), .dis_i(dis_cmd_i), .stat_o(stat)
  );

  always_comb begin
    unique case (bus_addr_i)
      A_MODE:  bus_rdata_o = {{(DATA_W-2){1'b0}}, mode_q};
      A_FLAG:  bus_rdata_o = {{(DATA_W-1){1'b0}}, flag};
      A_MASK:  bus_rdata_o = {{(DATA_W-1){1'b0}}, mask};
      default: bus_rdata_o = stat;
    endcase
  end

  assign irq_o  = flag & ~mask & stat[STAT_IE_BIT];
  assign save_o = ack_i ? stat : '0;
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic       en,
  input logic       dis,
  input logic       hit,
  input logic       flag,
  input logic       flag_we,
  input logic [1:0] mode,
  input logic       irq,
  input logic [7:0] stat
);
  // R8
  ack_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !stat[7]);

  // R7
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> !irq);

  // R9
  dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dis && en) |=> !stat[7]);

  // R10
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat[1] && !stat[5] && !stat[3] && !stat[2]);

  // R6
  none_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !flag && !flag_we) |=> !flag);

  // R11
  edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
endmodule

bind ext_irq_unit eirq_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .ack(ack_i), .en(en_cmd_i), .dis(dis_cmd_i),
  .hit(hit), .flag(flag), .flag_we(we_flag), .mode(mode_q), .irq(irq_o),
  .stat(stat)
);

// File: tb/sim_ext_irq_unit.sv
`timescale 1ns/1ps
module sim_ext_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0, wr = 1'b0, ack = 1'b0, en = 1'b0, dis = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rdata, save;
  logic       irq;

  int checks = 0, errors = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  // behavioural model state
  int m_s1, m_s2, m_prev, m_mode, m_flag, m_mask, m_stat;

  always #4 clk = ~clk;

  ext_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wd), .bus_rdata_o(rdata), .en_cmd_i(en), .dis_cmd_i(dis),
    .ack_i(ack), .irq_o(irq), .save_o(save)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_mode = 0; m_flag = 0; m_mask = 1; m_stat = 2;
    end else begin
      int hit_m, rise, fall;
      rise = (m_s2 == 1 && m_prev == 0);
      fall = (m_s2 == 0 && m_prev == 1);
      case (m_mode)
        0: hit_m = fall;
        1: hit_m = rise;
        3: hit_m = rise | fall;
        default: hit_m = 0;
      endcase
      if (hit_m != 0) m_flag = 1;
      else if (ack) m_flag = 0;
      else if (wr && addr == 1) m_flag = wd[0];
      if (wr && addr == 2) m_mask = wd[0];
      if (wr && addr == 0) m_mode = wd[1:0];
      if (wr && addr == 3) m_stat = (wd & 8'hD1) | 8'h02;
      if (ack || dis) m_stat = m_stat & 8'h7F;
      else if (en) m_stat = m_stat | 8'h80;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
    end
  end

  task automatic check8(input string req, input logic [7:0] act, input int exp);
    checks++;
    if (act !== exp[7:0]) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp[7:0], $time);
    end
  endtask

  task automatic compare_all();
    int exp_r;
    string rq;
    if (!chk_on) return;
    // R7
    check8("R7 irq", {7'd0, irq}, (m_flag == 1 && m_mask == 0 && m_stat[7] == 1) ? 1 : 0);
    // R8
    check8("R8 save", save, ack ? m_stat : 0);
    case (addr)
      2'd0: begin exp_r = m_mode; rq = "R2 mode read"; end
      2'd1: begin exp_r = m_flag; rq = "R12 flag read"; end
      2'd2: begin exp_r = m_mask; rq = "R12 mask read"; end
      default: begin exp_r = m_stat; rq = "R10 status read"; end
    endcase
    check8(rq, rdata, exp_r);
  endtask

  task automatic cyc(input logic p, input logic w, input logic [1:0] a,
                     input logic [7:0] d, input logic k, input logic e, input logic x);
    @(negedge clk);
    compare_all();
    pin = p; wr = w; addr = a; wd = d; ack = k; en = e; dis = x;
  endtask

  task automatic idle(input int n, input logic [1:0] a);
    for (int i = 0; i < n; i++) cyc(pin, 1'b0, a, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    cyc(pin, 1'b1, a, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic arm(input logic [1:0] code);
    wreg(2'd2, 8'h01); wreg(2'd0, {6'd0, code}); wreg(2'd1, 8'h00); wreg(2'd2, 8'h00);
    cyc(pin, 1'b0, 2'd1, 8'h00, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_on = 1'b1;
    // R1: reset values at every address
    for (int a = 0; a < 4; a++) idle(1, a[1:0]);
    // R2: reserved mode bits dropped
    wreg(2'd0, 8'hFF); idle(2, 2'd0);
    wreg(2'd0, 8'hFC); idle(2, 2'd0);
    // R4: rising edge, then R8 acknowledge
    arm(2'b01);
    cyc(1'b1, 1'b0, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0); idle(5, 2'd1);
    cyc(pin, 1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b0); idle(3, 2'd3);
    // R3: falling edge
    arm(2'b00);
    cyc(1'b0, 1'b0, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0); idle(5, 2'd1);
    // R5: both edges
    arm(2'b11);
    cyc(1'b1, 1'b0, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0); idle(5, 2'd1);
    wreg(2'd1, 8'h00);
    cyc(1'b0, 1'b0, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0); idle(5, 2'd1);
    // R6: prohibited code never sets the flag
    arm(2'b10);
    for (int i = 0; i < 8; i++) begin
      cyc(~pin, 1'b0, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0); idle(4, 2'd1);
    end
    // R11: software clear at every offset around a valid edge, and ack during edge
    arm(2'b11);
    for (int off = 0; off < 6; off++) begin
      cyc(~pin, 1'b0, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0);
      idle(off, 2'd1);
      wreg(2'd1, 8'h00);
      idle(6, 2'd1);
      cyc(pin, 1'b1, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0);
    end
    for (int off = 0; off < 5; off++) begin
      cyc(~pin, 1'b0, 2'd1, 8'h00, 1'b0, 1'b1, 1'b0);
      idle(off, 2'd1);
      cyc(pin, 1'b0, 2'd1, 8'h00, 1'b1, 1'b0, 1'b0);
      idle(5, 2'd1);
    end
    // R9: command priorities
    cyc(pin, 1'b0, 2'd3, 8'h00, 1'b0, 1'b1, 1'b1); idle(1, 2'd3);
    cyc(pin, 1'b0, 2'd3, 8'h00, 1'b0, 1'b1, 1'b0); idle(1, 2'd3);
    cyc(pin, 1'b0, 2'd3, 8'h00, 1'b1, 1'b1, 1'b0); idle(1, 2'd3);
    cyc(pin, 1'b1, 2'd3, 8'hFF, 1'b0, 1'b0, 1'b1); idle(1, 2'd3);
    // R10: status write keeps fixed bits
    wreg(2'd3, 8'hFF); idle(1, 2'd3);
    wreg(2'd3, 8'h00); idle(1, 2'd3);
    // R12: flag/mask bit 0 only
    wreg(2'd1, 8'hFE); idle(1, 2'd1);
    wreg(2'd2, 8'hFE); idle(1, 2'd2);
    // mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] ^ lfsr[9], (lfsr[3:1] == 3'b101), lfsr[5:4], {lfsr[11:6], lfsr[15:14]},
          (lfsr[8:6] == 3'b111), lfsr[12] & lfsr[2], (lfsr[13:11] == 3'b000));
    end
    idle(4, 2'd3);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule